// File: doc/BRIEF.md
# Receive Interrupt Moderation Timers

This block decides when the receive side of a network controller should raise its interrupt causes once a received packet has landed in memory. Each packet-completion pulse can start two delay timers. The first is a packet delay timer that restarts on every completion. The second is an absolute delay timer that, once started, runs to the end without being extended. If both delay settings are zero, the receive-timer cause is raised at once. The same completion pulse is also compared against a small-packet length threshold and against a fractional low-water mark on the descriptor ring, and each comparison can raise a cause of its own.

All causes leave as one-cycle pulses to a separate interrupt controller. That controller drives `irq_fire` back when it actually asserts an interrupt. This stops any running timer and folds the pending timeout into the receive-timer cause. Timer values count periods of an internal interrupt tick, which is derived from the core clock by a free-running divider of `TICK_DIV` cycles.

Each timer is a two-state machine, T_IDLE and T_RUN. The edge from T_IDLE to T_RUN is taken on a load. A T_RUN self-loop is taken on a reload, which only the packet timer accepts, and on a tick decrement. The edge from T_RUN back to T_IDLE is taken on stop, which is an expiry of either timer or a cancel. Only the per-timer load rule differs between the two timers.

Top module: `rx_irq_moderator`

## Requirements
- R1: After reset all three cause outputs are low and both timers are in T_IDLE.
- R2: A packet completion with non-zero `pkt_delay` loads the packet timer with that value, even when the timer is already in T_RUN.
- R3: A packet completion with non-zero `abs_delay` loads the absolute timer only when it is in T_IDLE. A completion that arrives while it runs leaves its count unchanged.
- R4: A packet completion with `pkt_delay` and `abs_delay` both zero gives a `cause_rxt` pulse in the next cycle.
- R5: A timer whose count is 1 when a tick occurs expires. Expiry of either timer gives a one-cycle `cause_rxt` pulse in the next cycle and returns both timers to T_IDLE, unless the same edge loads a timer.
- R6: `irq_fire` while either timer is in T_RUN gives a `cause_rxt` pulse in the next cycle and stops both timers. When neither timer runs, `irq_fire` raises nothing.
- R7: A `flush_req` pulse gives a `cause_rxt` pulse in the next cycle.
- R8: A packet completion with `pkt_len <= small_thresh` gives a `cause_small` pulse in the next cycle. `cause_small` is low in every other cycle.
- R9: `low_sel` selects the low-water test applied on a completion: 0 tests `desc_left*2 <= ring_len`, 1 tests `desc_left*4 <= ring_len`, and 2 tests `desc_left*8 <= ring_len`. A true test gives a `cause_low` pulse in the next cycle.
- R10: `low_sel` = 3 disables the low-water test, so `cause_low` stays low.
- R11: A tick occurs on every `TICK_DIV`-th rising edge counted from reset release, so a timer loaded with V expires on the V-th tick edge after its load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One-cycle pulse: a packet has been written to memory |
| pkt_len | input | LEN_W | Length of the completed packet |
| desc_left | input | RING_W | Descriptors left in the ring |
| ring_len | input | RING_W | Ring length |
| pkt_delay | input | TMR_W | Packet delay timer value in ticks; 0 disables it |
| abs_delay | input | TMR_W | Absolute delay timer value in ticks; 0 disables it |
| small_thresh | input | LEN_W | Small-packet length threshold |
| low_sel | input | 2 | Low-water fraction select (0 = 1/2, 1 = 1/4, 2 = 1/8, 3 = off) |
| flush_req | input | 1 | Pulse: the flush bit was written |
| irq_fire | input | 1 | Pulse: the interrupt controller has asserted; cancels the timers |
| cause_rxt | output | 1 | Receive-timer cause pulse |
| cause_small | output | 1 | Small-packet cause pulse |
| cause_low | output | 1 | Descriptor low-water cause pulse |

## Verification
The bench targets the boundaries of each comparison: a length exactly equal to the threshold, and a descriptor count exactly at and one above each ring fraction. A design that used a strict compare would miss the equal case, and one that decoded `low_sel` off by one fraction would fire at the wrong count. Random completions arrive while timers are mid-count. A packet timer that failed to restart would expire early, and an absolute timer that restarted would expire late. Cancels are also sent when no timer is running, which catches a design that raises a spurious timer cause. Collisions of a completion, an expiry and a cancel on the same edge check the stated load-over-stop priority.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    typedef enum logic {
        T_IDLE = 1'b0,
        T_RUN  = 1'b1
    } tmr_state_t;

    typedef enum logic [1:0] {
        LW_HALF    = 2'd0,
        LW_QUARTER = 2'd1,
        LW_EIGHTH  = 2'd2,
        LW_OFF     = 2'd3
    } low_sel_t;

endpackage

// File: rtl/rxm_prescaler.sv
module rxm_prescaler #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (pre_q == LAST)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign tick = (pre_q == LAST);
endmodule

// File: rtl/rxm_delay_timer.sv
module rxm_delay_timer
    import rxm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit RESTART = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stop,
    output logic             running,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    tmr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             load;

    generate
        if (RESTART) begin : g_restart
            assign load = start;
        end else begin : g_hold
            assign load = start && (state_q == T_IDLE);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            T_IDLE: begin
                if (load) begin
                    state_d = T_RUN;
                    cnt_d   = load_val;
                end
            end
            T_RUN: begin
                if (load) begin
                    cnt_d = load_val;
                end else if (stop) begin
                    state_d = T_IDLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = T_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign running = (state_q == T_RUN);
    assign expire  = running && tick && (cnt_q == CNT_W'(1));
    assign count   = cnt_q;
endmodule

// File: rtl/rxm_low_water.sv
module rxm_low_water
    import rxm_pkg::*;
#(
    parameter int RING_W = 16
) (
    input  logic [RING_W-1:0] desc_left,
    input  logic [RING_W-1:0] ring_len,
    input  logic [1:0]        low_sel,
    output logic              hit
);
    localparam int XW = RING_W + 3;

    logic [XW-1:0] left_x, ring_x;

    assign left_x = XW'(desc_left);
    assign ring_x = XW'(ring_len);

    always_comb begin
        unique case (low_sel_t'(low_sel))
            LW_HALF:    hit = (left_x << 1) <= ring_x;
            LW_QUARTER: hit = (left_x << 2) <= ring_x;
            LW_EIGHTH:  hit = (left_x << 3) <= ring_x;
            LW_OFF:     hit = 1'b0;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_irq_moderator.sv
module rx_irq_moderator
    import rxm_pkg::*;
#(
    parameter int LEN_W    = 14,
    parameter int RING_W   = 16,
    parameter int TMR_W    = 16,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_done,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [RING_W-1:0] desc_left,
    input  logic [RING_W-1:0] ring_len,
    input  logic [TMR_W-1:0]  pkt_delay,
    input  logic [TMR_W-1:0]  abs_delay,
    input  logic [LEN_W-1:0]  small_thresh,
    input  logic [1:0]        low_sel,
    input  logic              flush_req,
    input  logic              irq_fire,
    output logic              cause_rxt,
    output logic              cause_small,
    output logic              cause_low
);
    logic             tick;
    logic             pd_run, pd_exp, abs_run, abs_exp;
    logic [TMR_W-1:0] pd_cnt, abs_cnt;
    logic             stop_all, low_hit;
    logic             pd_en, abs_en;
    logic             rxt_d, small_d, low_d;

    assign pd_en    = (pkt_delay != '0);
    assign abs_en   = (abs_delay != '0);
    assign stop_all = pd_exp || abs_exp || irq_fire;

    rxm_prescaler #(.TICK_DIV(TICK_DIV)) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rxm_delay_timer #(.CNT_W(TMR_W), .RESTART(1'b1)) i_pd_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (pkt_done && pd_en),
        .load_val (pkt_delay),
        .stop     (stop_all),
        .running  (pd_run),
        .expire   (pd_exp),
        .count    (pd_cnt)
    );

    rxm_delay_timer #(.CNT_W(TMR_W), .RESTART(1'b0)) i_abs_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (pkt_done && abs_en),
        .load_val (abs_delay),
        .stop     (stop_all),
        .running  (abs_run),
        .expire   (abs_exp),
        .count    (abs_cnt)
    );

    rxm_low_water #(.RING_W(RING_W)) i_lw (
        .desc_left (desc_left),
        .ring_len  (ring_len),
        .low_sel   (low_sel),
        .hit       (low_hit)
    );

    always_comb begin
        rxt_d   = pd_exp || abs_exp || flush_req
               || (irq_fire && (pd_run || abs_run))
               || (pkt_done && !pd_en && !abs_en);
        small_d = pkt_done && (pkt_len <= small_thresh);
        low_d   = pkt_done && low_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_rxt   <= 1'b0;
            cause_small <= 1'b0;
            cause_low   <= 1'b0;
        end else begin
            cause_rxt   <= rxt_d;
            cause_small <= small_d;
            cause_low   <= low_d;
        end
    end
endmodule

// File: rtl/rx_irq_moderator_chk.sv
module rx_irq_moderator_chk #(
    parameter int LEN_W = 14,
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_done,
    input logic [LEN_W-1:0] pkt_len,
    input logic [LEN_W-1:0] small_thresh,
    input logic [TMR_W-1:0] pkt_delay,
    input logic [TMR_W-1:0] abs_delay,
    input logic [1:0]       low_sel,
    input logic             flush_req,
    input logic             irq_fire,
    input logic             pd_run,
    input logic             abs_run,
    input logic             pd_exp,
    input logic             abs_exp,
    input logic [TMR_W-1:0] abs_cnt,
    input logic             tick,
    input logic             cause_rxt,
    input logic             cause_small,
    input logic             cause_low
);
    // R7
    flush_rxt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> cause_rxt);

    // R4
    zero_delay_rxt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_delay == '0 && abs_delay == '0) |=> cause_rxt);

    // R8
    small_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_len <= small_thresh) |=> cause_small);

    // R8
    small_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_done |=> !cause_small);

    // R10
    low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_sel == 2'd3 || !pkt_done) |=> !cause_low);

    // R6
    cancel_rxt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fire && (pd_run || abs_run)) |=> cause_rxt);

    // R2
    pd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_delay != '0) |=> pd_run);

    // R3
    abs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abs_run && !irq_fire && !pd_exp && !abs_exp && !tick)
        |=> (abs_run && abs_cnt == $past(abs_cnt)));

    // R5
    expire_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pd_exp || abs_exp) && !pkt_done) |=> (cause_rxt && !pd_run && !abs_run));
endmodule

bind rx_irq_moderator rx_irq_moderator_chk #(.LEN_W(LEN_W), .TMR_W(TMR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pkt_done     (pkt_done),
    .pkt_len      (pkt_len),
    .small_thresh (small_thresh),
    .pkt_delay    (pkt_delay),
    .abs_delay    (abs_delay),
    .low_sel      (low_sel),
    .flush_req    (flush_req),
    .irq_fire     (irq_fire),
    .pd_run       (pd_run),
    .abs_run      (abs_run),
    .pd_exp       (pd_exp),
    .abs_exp      (abs_exp),
    .abs_cnt      (abs_cnt),
    .tick         (tick),
    .cause_rxt    (cause_rxt),
    .cause_small  (cause_small),
    .cause_low    (cause_low)
);

// File: tb/test_rx_irq_moderator.sv
module test_rx_irq_moderator;
    localparam int LEN_W    = 14;
    localparam int RING_W   = 16;
    localparam int TMR_W    = 16;
    localparam int TICK_DIV = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pkt_done = 1'b0;
    logic [LEN_W-1:0]  pkt_len = '0;
    logic [RING_W-1:0] desc_left = '0;
    logic [RING_W-1:0] ring_len = '0;
    logic [TMR_W-1:0]  pkt_delay = '0;
    logic [TMR_W-1:0]  abs_delay = '0;
    logic [LEN_W-1:0]  small_thresh = '0;
    logic [1:0]        low_sel = 2'd3;
    logic              flush_req = 1'b0;
    logic              irq_fire = 1'b0;
    logic              cause_rxt, cause_small, cause_low;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rx_irq_moderator #(
        .LEN_W(LEN_W), .RING_W(RING_W), .TMR_W(TMR_W), .TICK_DIV(TICK_DIV)
    ) i_rx_irq_moderator (
        .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_len(pkt_len),
        .desc_left(desc_left), .ring_len(ring_len), .pkt_delay(pkt_delay),
        .abs_delay(abs_delay), .small_thresh(small_thresh), .low_sel(low_sel),
        .flush_req(flush_req), .irq_fire(irq_fire), .cause_rxt(cause_rxt),
        .cause_small(cause_small), .cause_low(cause_low)
    );

    // Requirement-level reference model
    int    m_pre;
    bit    m_pd_run, m_ab_run;
    int    m_pd_cnt, m_ab_cnt;
    bit    m_rxt, m_small, m_low;
    string m_why;

    function automatic bit low_expect(int left, int ring, int sel);
        // R9 fractions, R10 off
        case (sel)
            0: return (left * 2) <= ring;
            1: return (left * 4) <= ring;
            2: return (left * 8) <= ring;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_pd_run = 0; m_ab_run = 0; m_pd_cnt = 0; m_ab_cnt = 0;
            m_rxt = 0; m_small = 0; m_low = 0; m_why = "R1";
        end else begin
            bit tk, pe, ae, stop, pl, al;
            tk = (m_pre == TICK_DIV - 1);                       // R11
            pe = m_pd_run && tk && m_pd_cnt == 1;
            ae = m_ab_run && tk && m_ab_cnt == 1;
            stop = pe || ae || irq_fire;
            pl = pkt_done && pkt_delay != 0;                    // R2
            al = pkt_done && abs_delay != 0 && !m_ab_run;       // R3
            m_rxt = 0; m_why = "";
            if (pe || ae)                       begin m_rxt = 1; m_why = "R5"; end
            if (irq_fire && (m_pd_run || m_ab_run)) begin m_rxt = 1; m_why = "R6"; end
            if (flush_req)                      begin m_rxt = 1; m_why = "R7"; end
            if (pkt_done && pkt_delay == 0 && abs_delay == 0) begin m_rxt = 1; m_why = "R4"; end
            if (m_why == "") m_why = "R6";
            m_small = pkt_done && (pkt_len <= small_thresh);  // R8
            m_low   = pkt_done && low_expect(int'(desc_left), int'(ring_len), int'(low_sel));
            if (pl) begin m_pd_run = 1; m_pd_cnt = int'(pkt_delay); end
            else if (m_pd_run && stop) begin m_pd_run = 0; m_pd_cnt = 0; end
            else if (m_pd_run && tk) m_pd_cnt = m_pd_cnt - 1;
            if (al) begin m_ab_run = 1; m_ab_cnt = int'(abs_delay); end
            else if (m_ab_run && stop) begin m_ab_run = 0; m_ab_cnt = 0; end
            else if (m_ab_run && tk) m_ab_cnt = m_ab_cnt - 1;
            m_pre = tk ? 0 : m_pre + 1;
        end
    end

    task automatic check_bit(string req, string what, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_bit(m_why, "cause_rxt", cause_rxt, m_rxt);
            check_bit("R8", "cause_small", cause_small, m_small);
            check_bit(low_sel == 2'd3 ? "R10" : "R9", "cause_low", cause_low, m_low);
        end
    end

    task automatic pulse_pkt(int len, int left, int ring, int sel);
        pkt_done = 1; pkt_len = LEN_W'(len); desc_left = RING_W'(left);
        ring_len = RING_W'(ring); low_sel = 2'(sel);
        @(negedge clk);
        pkt_done = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("R1", "cause_rxt@reset", cause_rxt, 1'b0);
        check_bit("R1", "cause_small@reset", cause_small, 1'b0);
        check_bit("R1", "cause_low@reset", cause_low, 1'b0);
        rst_n = 1;
        @(negedge clk);

        // R4: both delays zero
        pkt_delay = 0; abs_delay = 0; small_thresh = 64;
        pulse_pkt(100, 50, 64, 3); idle(3);
        // R8 boundary: length equal to threshold, then one above
        pulse_pkt(64, 50, 64, 3); pulse_pkt(65, 50, 64, 3); idle(2);
        // R9 boundaries for each fraction, R10 off with zero left
        pulse_pkt(200, 32, 64, 0); pulse_pkt(200, 33, 64, 0);
        pulse_pkt(200, 16, 64, 1); pulse_pkt(200, 17, 64, 1);
        pulse_pkt(200, 8, 64, 2);  pulse_pkt(200, 9, 64, 2);
        pulse_pkt(200, 0, 64, 3);  idle(2);
        // R6: cancel with no timer running raises nothing
        irq_fire = 1; @(negedge clk); irq_fire = 0; idle(2);
        // R7: flush
        flush_req = 1; @(negedge clk); flush_req = 0; idle(2);
        // R2/R11: restart of packet timer keeps pushing expiry
        pkt_delay = 3; abs_delay = 0;
        pulse_pkt(300, 60, 64, 3); idle(5);
        pulse_pkt(300, 60, 64, 3); idle(5);
        pulse_pkt(300, 60, 64, 3); idle(20);
        // R3/R5: absolute timer not extended by later completions
        pkt_delay = 6; abs_delay = 4;
        repeat (6) begin pulse_pkt(300, 60, 64, 3); idle(3); end
        idle(40);
        // R6: cancel while running
        pulse_pkt(300, 60, 64, 3); idle(2);
        irq_fire = 1; @(negedge clk); irq_fire = 0; idle(40);

        // Constrained random mix
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(0, 199) == 0) begin
                pkt_delay    = TMR_W'($urandom_range(0, 8));
                abs_delay    = TMR_W'($urandom_range(0, 12));
                small_thresh = LEN_W'($urandom_range(0, 256));
            end
            pkt_done  = ($urandom_range(0, 7) == 0);
            pkt_len   = LEN_W'($urandom_range(0, 400));
            ring_len  = RING_W'($urandom_range(8, 128));
            desc_left = RING_W'($urandom_range(0, int'(ring_len)));
            low_sel   = 2'($urandom_range(0, 3));
            flush_req = ($urandom_range(0, 59) == 0);
            irq_fire  = ($urandom_range(0, 39) == 0);
            @(negedge clk);
        end
        pkt_done = 0; flush_req = 0; irq_fire = 0;
        idle(60);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule